// File: doc/BRIEF.md
# Video Memory Dirty-Page Tracker

This block keeps one flag per 4096-byte page of video memory so that the display refresh logic redraws only the scan lines whose backing memory has changed. Each byte the host writes into video memory reports its address on the mark port, which sets the flag of the page holding that byte. When a planar, latched write is marked, the address given is plane-relative, and the block scales it by four before it selects the page.

During scan-out the refresh logic asks, for each line, whether the line must be drawn again. It gives the line's start address and its length in bytes, and may force a redraw. The answer comes back one cycle later. The block also keeps the lowest first page and the highest last page of the lines that needed a redraw during the current frame. A frame-end strobe clears every flag inside that span and then starts a new, empty span. The contents of video memory and the conversion to pixels are handled by other blocks.

Top module: `dpt_dirty_tracker`

## Requirements
- R1: After reset every page flag is clear, `rsp_valid` is low and no page span is held, so a query with no force reports no redraw.
- R2: A linear mark sets the flag of page `mark_addr[ADDR_W-1:12]`.
- R3: A planar mark (`mark_planar`=1) sets the flag of the page that holds byte address `mark_addr`×4, which is page `mark_addr[ADDR_W-3:10]`.
- R4: `rsp_valid` is high in exactly the cycle after an accepted query, and low in every other cycle.
- R5: A query with `qry_force`=1 reports `rsp_redraw`=1 whatever the flags hold.
- R6: A query reports a redraw when the flag of its first page (from `qry_start`) or its last page (from `qry_start`+`qry_len`−1) is set.
- R7: When the last page lies two or more pages past the first page, the page right after the first page is tested as well, and no other inner page is tested.
- R8: On `frame_end`, the flags from the smallest first page to the largest last page of the queries that reported a redraw since the previous frame end are cleared, and flags outside that span keep their values.
- R9: A `frame_end` with no query that reported a redraw since the previous frame end clears no flag.
- R10: When a mark and a frame-end clear hit the same page in the same cycle, that page's flag ends up set.
- R11: A query sees the flags as they stood before any mark made in the same cycle. A mark becomes visible to queries in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mark_valid | input | 1 | A byte write to video memory occurred |
| mark_planar | input | 1 | The marked address is plane-relative and is scaled by 4 |
| mark_addr | input | ADDR_W | Address of the written byte |
| qry_valid | input | 1 | Line query request |
| qry_start | input | ADDR_W | Byte address where the line starts |
| qry_len | input | ADDR_W+1 | Line length in bytes |
| qry_force | input | 1 | Forces a redraw answer |
| frame_end | input | 1 | Clears the page span of the current frame |
| rsp_valid | output | 1 | Query answer is valid |
| rsp_redraw | output | 1 | The queried line must be redrawn |

## Verification
The assertions assume that every query has a nonzero length and that the line ends inside video memory, so the last page is never below the first page and no page index wraps around. All query lengths in the stimulus are at least one byte, and every line ends at or below the top of memory; the longest line covers exactly the whole memory. Marks and frame ends may arrive in any cycle. The bench exercises the same-cycle combinations on purpose: a mark with a frame end, and a mark with a query.

// File: rtl/dpt_pkg.sv
// Package: shared constants for the dirty-page tracker.
// Assumes pages are a fixed 4096 bytes and that planar addresses are
// scaled by four (one byte per plane) to form byte addresses.
package dpt_pkg;
    localparam int unsigned PAGE_SHIFT  = 12;
    localparam int unsigned PLANE_SHIFT = 2;
endpackage

// File: rtl/dpt_page_map.sv
// Module: dpt_page_map
// Turns a marked write address into a page index. In planar mode the
// address is plane-relative and is scaled by four before the page bits
// are taken. Assumes ADDR_W > PAGE_SHIFT + PLANE_SHIFT.
module dpt_page_map
    import dpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    localparam int unsigned PG_W  = ADDR_W - PAGE_SHIFT
) (
    input  logic              planar,
    input  logic [ADDR_W-1:0] addr,
    output logic [PG_W-1:0]   page
);
    logic [ADDR_W-1:0] byte_addr;

    // Pick the byte address: direct or plane-relative times four.
    always_comb begin
        if (planar)
            byte_addr = {addr[ADDR_W-PLANE_SHIFT-1:0], {PLANE_SHIFT{1'b0}}};
        else
            byte_addr = addr;
    end

    assign page = byte_addr[ADDR_W-1:PAGE_SHIFT];
endmodule

// File: rtl/dpt_flag_array.sv
// Module: dpt_flag_array
// One flag per page. A set request targets a single page. A clear request
// covers the inclusive range [clr_lo, clr_hi]. A set beats a clear on the
// same page. Assumes clr_lo <= clr_hi whenever clr_en is high.
module dpt_flag_array #(
    parameter int unsigned NPAGE = 64,
    localparam int unsigned PG_W = $clog2(NPAGE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [PG_W-1:0]  set_page,
    input  logic             clr_en,
    input  logic [PG_W-1:0]  clr_lo,
    input  logic [PG_W-1:0]  clr_hi,
    output logic [NPAGE-1:0] flags
);
    for (genvar i = 0; i < NPAGE; i++) begin : g_page
        logic set_hit;
        logic clr_hit;
        assign set_hit = set_en && (set_page == PG_W'(i));
        assign clr_hit = clr_en && (PG_W'(i) >= clr_lo) && (PG_W'(i) <= clr_hi);

        // Update one page flag; a set takes priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (set_hit) flags[i] <= 1'b1;
            else if (clr_hit) flags[i] <= 1'b0;
        end
    end

    // R2 / R10: a set page reads as dirty in the next cycle, clear or not.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> flags[$past(set_page)]);

    // R8: the bottom page of a cleared range is clean afterwards unless it was set.
    a_r8_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_page == clr_lo)) |=> !flags[$past(clr_lo)]);

    // R9: with no request, no flag moves.
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(flags));
endmodule

// File: rtl/dpt_line_check.sv
// Module: dpt_line_check
// Combinational redraw test for one scan line. It tests the first page,
// the last page and, for lines that reach two or more pages past the
// first, the page right after the first. Assumes len >= 1 and that the
// line ends inside memory, so last >= first.
module dpt_line_check
    import dpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    localparam int unsigned PG_W  = ADDR_W - PAGE_SHIFT,
    localparam int unsigned NPAGE = 1 << PG_W
) (
    input  logic [NPAGE-1:0] flags,
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W:0]   len,
    input  logic              force_upd,
    output logic [PG_W-1:0]   first_pg,
    output logic [PG_W-1:0]   last_pg,
    output logic              redraw
);
    logic [ADDR_W:0]   end_addr;
    logic [PG_W-1:0]   next_pg;
    logic [PG_W-1:0]   span;
    logic              wide;

    // Locate the first, last and second page of the line.
    always_comb begin
        end_addr = {1'b0, start} + len - 1'b1;
        first_pg = start[ADDR_W-1:PAGE_SHIFT];
        last_pg  = end_addr[ADDR_W-1:PAGE_SHIFT];
        next_pg  = first_pg + 1'b1;
        span     = last_pg - first_pg;
        wide     = span > PG_W'(1);
    end

    // Combine the page tests with the forced update.
    always_comb begin
        redraw = force_upd || flags[first_pg] || flags[last_pg]
                 || (wide && flags[next_pg]);
    end
endmodule

// File: rtl/dpt_span_track.sv
// Module: dpt_span_track
// Keeps the smallest first page and largest last page of the lines that
// needed a redraw in the current frame. A frame end hands the span out for
// clearing and restarts it. A redraw in that same cycle opens the new span.
module dpt_span_track #(
    parameter int unsigned PG_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [PG_W-1:0] hit_first,
    input  logic [PG_W-1:0] hit_last,
    input  logic            frame_end,
    output logic            span_vld,
    output logic [PG_W-1:0] span_lo,
    output logic [PG_W-1:0] span_hi
);
    // Grow the span on each redraw line; restart it at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_vld <= 1'b0;
            span_lo  <= '0;
            span_hi  <= '0;
        end else if (hit && (frame_end || !span_vld)) begin
            span_vld <= 1'b1;
            span_lo  <= hit_first;
            span_hi  <= hit_last;
        end else if (frame_end) begin
            span_vld <= 1'b0;
        end else if (hit) begin
            if (hit_first < span_lo) span_lo <= hit_first;
            if (hit_last  > span_hi) span_hi <= hit_last;
        end
    end

    // R8: a held span is never inverted.
    a_r8_span_order: assert property (@(posedge clk) disable iff (!rst_n)
        span_vld |-> (span_lo <= span_hi));

    // R9: a frame end without a redraw line leaves no span behind.
    a_r9_span_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !hit) |=> !span_vld);
endmodule

// File: rtl/dpt_dirty_tracker.sv
// Module: dpt_dirty_tracker (top)
// Dirty-page tracker for video memory of 2**ADDR_W bytes in 4096-byte
// pages. Marks set page flags, line queries are answered one cycle later,
// and frame end clears the span of pages used by redrawn lines.
// Assumes every query has len >= 1 and ends inside memory.
module dpt_dirty_tracker
    import dpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mark_valid,
    input  logic              mark_planar,
    input  logic [ADDR_W-1:0] mark_addr,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_start,
    input  logic [ADDR_W:0]   qry_len,
    input  logic              qry_force,
    input  logic              frame_end,
    output logic              rsp_valid,
    output logic              rsp_redraw
);
    localparam int unsigned PG_W  = ADDR_W - PAGE_SHIFT;
    localparam int unsigned NPAGE = 1 << PG_W;
    localparam logic [ADDR_W+1:0] MEM_BYTES = (ADDR_W+2)'(1) << ADDR_W;

    logic [PG_W-1:0]  mark_page;
    logic [NPAGE-1:0] flags;
    logic [PG_W-1:0]  first_pg;
    logic [PG_W-1:0]  last_pg;
    logic             line_redraw;
    logic             span_vld;
    logic [PG_W-1:0]  span_lo;
    logic [PG_W-1:0]  span_hi;

    dpt_page_map #(.ADDR_W(ADDR_W)) u_map (
        .planar (mark_planar),
        .addr   (mark_addr),
        .page   (mark_page)
    );

    dpt_flag_array #(.NPAGE(NPAGE)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (mark_valid),
        .set_page (mark_page),
        .clr_en   (frame_end && span_vld),
        .clr_lo   (span_lo),
        .clr_hi   (span_hi),
        .flags    (flags)
    );

    dpt_line_check #(.ADDR_W(ADDR_W)) u_line (
        .flags     (flags),
        .start     (qry_start),
        .len       (qry_len),
        .force_upd (qry_force),
        .first_pg  (first_pg),
        .last_pg   (last_pg),
        .redraw    (line_redraw)
    );

    dpt_span_track #(.PG_W(PG_W)) u_span (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (qry_valid && line_redraw),
        .hit_first (first_pg),
        .hit_last  (last_pg),
        .frame_end (frame_end),
        .span_vld  (span_vld),
        .span_lo   (span_lo),
        .span_hi   (span_hi)
    );

    // Register the query answer for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_redraw <= 1'b0;
        end else begin
            rsp_valid  <= qry_valid;
            rsp_redraw <= qry_valid && line_redraw;
        end
    end

    // R4: an answer follows each query, and only a query.
    a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> rsp_valid);
    a_r4_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_valid |=> !rsp_valid);

    // R5: a forced query always answers redraw.
    a_r5_force: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && qry_force) |=> rsp_redraw);

    // R6: input assumption; the line is non-empty and ends inside memory.
    a_r6_line_inside: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |-> (qry_len != '0) &&
                      (({1'b0, qry_start} + {1'b0, qry_len}) <= MEM_BYTES));
endmodule

// File: tb/tb_dpt_dirty_tracker.sv
`timescale 1ns/1ps
module tb_dpt_dirty_tracker;
    localparam int unsigned ADDR_W = 18;
    // Operation codes used by the stimulus table.
    localparam logic [2:0] OP_MARK  = 3'd0;
    localparam logic [2:0] OP_PMARK = 3'd1;
    localparam logic [2:0] OP_QRY   = 3'd2;
    localparam logic [2:0] OP_FEND  = 3'd3;
    localparam logic [2:0] OP_MFEND = 3'd4;
    localparam logic [2:0] OP_QMARK = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mark_valid = 1'b0;
    logic              mark_planar = 1'b0;
    logic [ADDR_W-1:0] mark_addr = '0;
    logic              qry_valid = 1'b0;
    logic [ADDR_W-1:0] qry_start = '0;
    logic [ADDR_W:0]   qry_len = '0;
    logic              qry_force = 1'b0;
    logic              frame_end = 1'b0;
    logic              rsp_valid;
    logic              rsp_redraw;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dpt_dirty_tracker #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .mark_valid(mark_valid), .mark_planar(mark_planar), .mark_addr(mark_addr),
        .qry_valid(qry_valid), .qry_start(qry_start), .qry_len(qry_len),
        .qry_force(qry_force), .frame_end(frame_end),
        .rsp_valid(rsp_valid), .rsp_redraw(rsp_redraw)
    );

    // Table entry: {op[2:0], addr[17:0], len[18:0], force, expected redraw}
    localparam int NVEC = 16;
    localparam logic [41:0] VEC [NVEC] = '{
        {OP_MARK,  18'h03010, 19'd0,      1'b0, 1'b0},  // R2 page 3
        {OP_QRY,   18'h03000, 19'd16,     1'b0, 1'b1},  // R2/R6 first page dirty
        {OP_QRY,   18'h00000, 19'h00100,  1'b0, 1'b0},  // R6 clean page 0
        {OP_PMARK, 18'h01400, 19'd0,      1'b0, 1'b0},  // R3 -> page 5
        {OP_QRY,   18'h04F00, 19'h00200,  1'b0, 1'b1},  // R3/R6 last page 5 dirty
        {OP_QRY,   18'h06000, 19'h00100,  1'b1, 1'b1},  // R5 forced
        {OP_MARK,  18'h0A000, 19'd0,      1'b0, 1'b0},  // page 10
        {OP_QRY,   18'h08800, 19'h03000,  1'b0, 1'b0},  // R7 pages 8..11, inner 10 untested
        {OP_MARK,  18'h09FFF, 19'd0,      1'b0, 1'b0},  // page 9
        {OP_QRY,   18'h08800, 19'h03000,  1'b0, 1'b1},  // R7 page after first dirty
        {OP_FEND,  18'h00000, 19'd0,      1'b0, 1'b0},  // R8 clear 3..11
        {OP_QRY,   18'h0A000, 19'd1,      1'b0, 1'b0},  // R8 page 10 cleared
        {OP_MARK,  18'h3F000, 19'd0,      1'b0, 1'b0},  // top page 63
        {OP_FEND,  18'h00000, 19'd0,      1'b0, 1'b0},  // R9 no span, nothing cleared
        {OP_QRY,   18'h3F000, 19'h01000,  1'b0, 1'b1},  // R9 page 63 still dirty
        {OP_QRY,   18'h05000, 19'd1,      1'b0, 1'b0}   // R8 page 5 cleared
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Apply one operation for one cycle, then look at the answer.
    task automatic do_op(input logic [2:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [ADDR_W:0] len, input logic frc,
                         input logic exp, input string tag);
        @(negedge clk);
        mark_valid  = (op == OP_MARK) || (op == OP_PMARK) || (op == OP_MFEND) || (op == OP_QMARK);
        mark_planar = (op == OP_PMARK);
        mark_addr   = addr;
        qry_valid   = (op == OP_QRY) || (op == OP_QMARK);
        qry_start   = addr;
        qry_len     = len;
        qry_force   = frc;
        frame_end   = (op == OP_FEND) || (op == OP_MFEND);
        @(negedge clk);
        if (qry_valid) begin
            check({tag, " R4 rsp_valid"}, rsp_valid, 1'b1);
            check({tag, " redraw"}, rsp_redraw, exp);
        end else begin
            check({tag, " R4 no rsp"}, rsp_valid, 1'b0);
        end
        mark_valid = 1'b0; mark_planar = 1'b0; qry_valid = 1'b0;
        qry_force = 1'b0; frame_end = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        @(negedge clk);
        check("R1 rsp_valid after reset", rsp_valid, 1'b0);
        do_op(OP_QRY, 18'h00000, 19'h40000, 1'b0, 1'b0, "R1 full-memory query clean");

        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i][41:39], VEC[i][38:21], VEC[i][20:2], VEC[i][1], VEC[i][0],
                  $sformatf("vec%0d", i));
        end

        // R10: mark and clear on page 63 together; the mark wins.
        do_op(OP_MFEND, 18'h3F800, 19'd0, 1'b0, 1'b0, "R10 mark+fend");
        do_op(OP_QRY,   18'h3F000, 19'd1, 1'b0, 1'b1, "R10 page 63 kept");
        do_op(OP_FEND,  18'h00000, 19'd0, 1'b0, 1'b0, "R8 fend");
        do_op(OP_QRY,   18'h3F000, 19'd1, 1'b0, 1'b0, "R8 page 63 cleared");

        // R11: a mark is not visible to a query in the same cycle.
        do_op(OP_QMARK, 18'h20000, 19'd1, 1'b0, 1'b0, "R11 same-cycle query");
        do_op(OP_QRY,   18'h20000, 19'd1, 1'b0, 1'b1, "R11 next-cycle query");

        // R8: pages outside the span survive a frame end.
        do_op(OP_MARK,  18'h28000, 19'd0, 1'b0, 1'b0, "R8 mark page 40");
        do_op(OP_FEND,  18'h00000, 19'd0, 1'b0, 1'b0, "R8 fend span 32");
        do_op(OP_QRY,   18'h28000, 19'd1, 1'b0, 1'b1, "R8 page 40 kept");
        do_op(OP_QRY,   18'h20000, 19'd1, 1'b0, 1'b0, "R8 page 32 cleared");

        // R9: a frame end with no redraw line clears nothing.
        do_op(OP_FEND,  18'h00000, 19'd0, 1'b0, 1'b0, "R9 fend span 40");
        do_op(OP_MARK,  18'h30000, 19'd0, 1'b0, 1'b0, "R9 mark page 48");
        do_op(OP_FEND,  18'h00000, 19'd0, 1'b0, 1'b0, "R9 empty fend");
        do_op(OP_QRY,   18'h30000, 19'd1, 1'b0, 1'b1, "R9 page 48 kept");

        // R1: reset in the middle of a run clears every flag.
        do_op(OP_MARK,  18'h01000, 19'd0, 1'b0, 1'b0, "R1 mark page 1");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after mid reset", rsp_valid, 1'b0);
        do_op(OP_QRY,   18'h01000, 19'd1, 1'b0, 1'b0, "R1 page 1 after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule